// File: doc/BRIEF.md
# SPI Bulk Write Packetizer

This block carries out the data phase of a bulk write over a serial peripheral link. A single `start` pulse latches a total byte count, a CRC-enable flag and a 3-bit size code. The block then draws payload bytes from a ready/valid byte stream and shifts them out on `mosi`, one bit per clock, with the most significant bit first. The bytes are cut into packets, and no packet holds more payload than the coded maximum.

Each packet opens with a header byte. Its low bits tell the receiver whether the packet is the first of several, one in the middle, or the one that finishes the transfer. When CRC is enabled, every payload is followed by two trailer bytes, both always zero. The link has a fault with single-byte transfers, so a one-byte request is widened to two bytes. The real byte goes first and a zero pad byte follows it. The command frame that comes before this phase, and any response read after it, are handled elsewhere.

Top module: `spi_bulk_packetizer`

## Requirements
- R1: Every header byte has its upper nibble equal to 0xF and bits 3:2 equal to zero. Bits 1:0 hold the order code.
- R2: Each byte leaves on `mosi` most significant bit first, one bit per clock, with `mosi_en` high for each of those bits. A gap between bytes only opens while the stream has no valid payload byte to offer.
- R3: The order code is 3 when the bytes still to send fit in one packet. Otherwise it is 1 for the opening packet and 2 for every later packet.
- R4: The payload of each packet has a length equal to the smaller of the remaining byte count and the coded maximum.
- R5: With `crc_en` set, two 0x00 bytes follow every payload. With it clear, no trailer bytes are sent.
- R6: Size codes 0 to 5 select a maximum of 256 shifted left by the code (256 up to 8192 bytes). Codes 6 and 7 select 8192.
- R7: A byte count of 1 produces a single packet with a two-byte payload: the streamed byte, then 0x00. Exactly one byte is taken from the stream.
- R8: `in_ready` is high only while the block is busy. Over one transfer the stream hands over exactly the requested number of bytes.
- R9: `done` is a one-cycle pulse in the clock after the last bit of the final packet. A byte count of 0 gives a `done` pulse and sends no bits.
- R10: A `start` pulse that arrives while `busy` is high has no effect on the transfer in progress.
- R11: After reset, `busy`, `done`, `mosi_en` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer; ignored while busy |
| byte_count | input | CNT_W | Total payload bytes, latched on start |
| crc_en | input | 1 | Append two zero trailer bytes per packet |
| size_code | input | 3 | Maximum packet size code, latched on start |
| in_data | input | 8 | Payload byte from the stream |
| in_valid | input | 1 | Stream byte is valid |
| in_ready | output | 1 | Block accepts a payload byte this cycle |
| mosi | output | 1 | Serial data out, MSB first |
| mosi_en | output | 1 | `mosi` carries a bit this cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
If the remaining count or the packet counter in the sequencer goes wrong, the next header byte shows the fault: it carries a wrong order code, or it shows up one payload byte early or late. That header reaches `mosi` within one packet length of the error. A wrong trailer or pad state changes the bytes right after the payload, so the error is visible within the next 16 bits. A stuck final state shows up as a missing or misplaced `done` pulse. The bench rebuilds the complete expected byte stream from the requirements and compares every serial bit, so a fault is reported in the cycle where the first wrong bit appears.

// File: rtl/spi_pktz_pkg.sv
// Shared types and constants for the bulk write packetizer.
// Assumes: header tag and order codes are fixed by the receiver's decoder.
package spi_pktz_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAY,
        ST_TRL0,
        ST_TRL1,
        ST_FIN
    } seq_state_t;

    localparam logic [3:0] HDR_TAG     = 4'hF;
    localparam logic [1:0] ORD_OPEN    = 2'd1;
    localparam logic [1:0] ORD_MIDDLE  = 2'd2;
    localparam logic [1:0] ORD_CLOSING = 2'd3;

endpackage

// File: rtl/pkt_size_decode.sv
// Maps the 3-bit packet size code to a maximum payload byte count.
// Codes 0..MAX_CODE give 2**MIN_LOG shifted by the code; larger codes clamp
// to the biggest size. Assumes OUT_W is wide enough for the biggest size.
module pkt_size_decode #(
    parameter int MIN_LOG  = 8,
    parameter int MAX_CODE = 5,
    parameter int OUT_W    = 16
) (
    input  logic [2:0]       size_code,
    output logic [OUT_W-1:0] max_bytes
);
    localparam logic [OUT_W-1:0] BASE = OUT_W'(1) << MIN_LOG;

    // Decode the code, clamping codes above MAX_CODE.
    always_comb begin
        if (int'(size_code) > MAX_CODE)
            max_bytes = BASE << MAX_CODE;
        else
            max_bytes = BASE << size_code;
    end
endmodule

// File: rtl/byte_shifter.sv
// Parallel-to-serial byte shifter, MSB first, one bit per clock.
// A new byte can load while the last bit of the previous one is on the line,
// so back-to-back bytes leave without a gap.
module byte_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_data,
    output logic       can_load,
    output logic       mosi,
    output logic       mosi_en
);
    logic [7:0] sh_q;
    logic [3:0] bits_q;

    assign can_load = (bits_q <= 4'd1);
    assign mosi     = sh_q[7];
    assign mosi_en  = (bits_q != 4'd0);

    // Load a new byte or shift the current one left by a bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            bits_q <= '0;
        end else if (load) begin
            sh_q   <= load_data;
            bits_q <= 4'd8;
        end else if (bits_q != 4'd0) begin
            sh_q   <= {sh_q[6:0], 1'b0};
            bits_q <= bits_q - 4'd1;
        end
    end

    assert_load_drives_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> mosi_en);
    assert_bits_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bits_q <= 4'd8);
endmodule

// File: rtl/pkt_sequencer.sv
// Chooses the byte for each serial slot: header, payload, pad or trailer.
// Tracks the remaining count and the payload still due in the current packet.
// Assumes max_bytes is stable while busy (it comes from the latched code).
module pkt_sequencer
    import spi_pktz_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             crc_en,
    input  logic [2:0]       size_code,
    input  logic [CNT_W-1:0] max_bytes,
    output logic [2:0]       code_q,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    input  logic             can_load,
    output logic             byte_valid,
    output logic [7:0]       byte_data,
    output logic             busy,
    output logic             done
);
    seq_state_t       state_q;
    logic [CNT_W-1:0] remaining_q;
    logic [CNT_W-1:0] pkt_left_q;
    logic             first_q;
    logic             pad_q;
    logic             crc_q;
    logic             done_q;

    logic             fits;
    logic [1:0]       order;
    logic [CNT_W-1:0] pkt_len;
    logic             pad_slot;
    logic             take;

    assign fits     = (remaining_q <= max_bytes);
    assign pkt_len  = fits ? remaining_q : max_bytes;
    assign pad_slot = pad_q && (pkt_left_q == CNT_W'(1));
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign in_ready = (state_q == ST_PAY) && !pad_slot && can_load;
    assign take     = byte_valid && can_load;

    // Order code: closing packet when the rest fits, else opening or middle.
    always_comb begin
        if (fits)
            order = ORD_CLOSING;
        else if (first_q)
            order = ORD_OPEN;
        else
            order = ORD_MIDDLE;
    end

    // Offer the byte that belongs to the current slot.
    always_comb begin
        byte_valid = 1'b0;
        byte_data  = 8'h00;
        case (state_q)
            ST_HDR: begin
                byte_valid = 1'b1;
                byte_data  = {HDR_TAG, 2'b00, order};
            end
            ST_PAY: begin
                if (pad_slot) begin
                    byte_valid = 1'b1;
                end else begin
                    byte_valid = in_valid;
                    byte_data  = in_data;
                end
            end
            ST_TRL0, ST_TRL1: byte_valid = 1'b1;
            default: ;
        endcase
    end

    // Advance the slot sequence and its counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            remaining_q <= '0;
            pkt_left_q  <= '0;
            first_q     <= 1'b0;
            pad_q       <= 1'b0;
            crc_q       <= 1'b0;
            code_q      <= '0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        crc_q   <= crc_en;
                        code_q  <= size_code;
                        first_q <= 1'b1;
                        pad_q   <= (byte_count == CNT_W'(1));
                        remaining_q <= (byte_count == CNT_W'(1)) ? CNT_W'(2) : byte_count;
                        state_q <= (byte_count == '0) ? ST_FIN : ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (take) begin
                        pkt_left_q <= pkt_len;
                        first_q    <= 1'b0;
                        state_q    <= ST_PAY;
                    end
                end
                ST_PAY: begin
                    if (take) begin
                        remaining_q <= remaining_q - CNT_W'(1);
                        pkt_left_q  <= pkt_left_q - CNT_W'(1);
                        if (pkt_left_q == CNT_W'(1)) begin
                            if (crc_q)
                                state_q <= ST_TRL0;
                            else if (remaining_q == CNT_W'(1))
                                state_q <= ST_FIN;
                            else
                                state_q <= ST_HDR;
                        end
                    end
                end
                ST_TRL0: begin
                    if (take) state_q <= ST_TRL1;
                end
                ST_TRL1: begin
                    if (take) state_q <= (remaining_q == '0) ? ST_FIN : ST_HDR;
                end
                ST_FIN: begin
                    if (can_load) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_pkt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAY) |-> (pkt_left_q != '0 && pkt_left_q <= max_bytes));
    assert_trailer_needs_crc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRL0 || state_q == ST_TRL1) |-> crc_q);
    assert_size_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(max_bytes));
    assert_ready_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(crc_q) && $stable(code_q)));
endmodule

// File: rtl/spi_bulk_packetizer.sv
// Top of the bulk write packetizer: sequencer, size decoder and shifter.
// Assumes the command frame has already gone out and the link clock runs
// one bit per clk while mosi_en is high.
module spi_bulk_packetizer #(
    parameter int CNT_W    = 16,
    parameter int MIN_LOG  = 8,
    parameter int MAX_CODE = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             crc_en,
    input  logic [2:0]       size_code,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             mosi,
    output logic             mosi_en,
    output logic             busy,
    output logic             done
);
    logic [2:0]       code_q;
    logic [CNT_W-1:0] max_bytes;
    logic             can_load;
    logic             byte_valid;
    logic [7:0]       byte_data;

    pkt_size_decode #(
        .MIN_LOG  (MIN_LOG),
        .MAX_CODE (MAX_CODE),
        .OUT_W    (CNT_W)
    ) u_size (
        .size_code (code_q),
        .max_bytes (max_bytes)
    );

    pkt_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .byte_count (byte_count),
        .crc_en     (crc_en),
        .size_code  (size_code),
        .max_bytes  (max_bytes),
        .code_q     (code_q),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .can_load   (can_load),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .busy       (busy),
        .done       (done)
    );

    byte_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (byte_valid && can_load),
        .load_data (byte_data),
        .can_load  (can_load),
        .mosi      (mosi),
        .mosi_en   (mosi_en)
    );

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !in_ready);
endmodule

// File: tb/spi_bulk_packetizer_tb.sv
// Bench: builds the expected byte stream behaviourally and checks every bit.
module spi_bulk_packetizer_tb;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] byte_count = '0;
    logic             crc_en = 1'b0;
    logic [2:0]       size_code = '0;
    logic [7:0]       in_data = '0;
    logic             in_valid = 1'b0;
    logic             in_ready, mosi, mosi_en, busy, done;

    int checks = 0;
    int failures = 0;

    byte unsigned exp_q[$];
    int           kind_q[$];   // 0 header, 1 payload, 2 trailer, 3 pad
    int  bit_idx = 0;
    int  ptr = 0;
    int  fires = 0;
    int  seed = 0;
    int  stall = 0;
    bit  last_fire = 0;
    bit  prev_en = 0;

    always #4 clk = ~clk;   // 125 MHz

    spi_bulk_packetizer #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
        .crc_en(crc_en), .size_code(size_code), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .mosi(mosi),
        .mosi_en(mosi_en), .busy(busy), .done(done)
    );

    function automatic byte unsigned pat(int s, int k);
        return byte'((k * 37 + s * 11 + 5) & 8'hFF);
    endfunction

    function automatic string kind_name(int k);
        case (k)
            0: return "R1/R3 header";
            1: return "R4 payload";
            2: return "R5 trailer";
            default: return "R7 pad";
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock monitor and stream source.
    always @(negedge clk) begin
        if (last_fire) begin
            ptr++;
            fires++;
        end
        if (!busy) check(!in_ready, "R8 in_ready while idle", in_ready, 0);
        if (mosi_en) begin
            if (exp_q.size() == 0) begin
                check(0, "R2 unexpected bit", mosi, 0);
            end else begin
                if (mosi !== exp_q[0][7 - bit_idx]) begin
                    check(0, {kind_name(kind_q[0]), " bit"}, mosi, exp_q[0][7 - bit_idx]);
                end
                bit_idx++;
                if (bit_idx == 8) begin
                    checks++;
                    bit_idx = 0;
                    void'(exp_q.pop_front());
                    void'(kind_q.pop_front());
                end
            end
        end
        prev_en = mosi_en;
        in_valid = ($urandom % 100) >= stall;
        in_data  = pat(seed, ptr);
        last_fire = in_valid && in_ready;
    end

    // Build the expected stream from the requirements.
    task automatic plan(int count, bit crc, int code);
        int n    = (count == 1) ? 2 : count;
        int maxb = (code > 5) ? 8192 : (256 << code);   // R6
        int rem  = n;
        int k    = 0;
        bit first = 1;
        while (rem > 0) begin
            int len = (rem < maxb) ? rem : maxb;         // R4
            int ord = (rem <= maxb) ? 3 : (first ? 1 : 2);   // R3
            exp_q.push_back(byte'(8'hF0 | ord));         // R1
            kind_q.push_back(0);
            for (int j = 0; j < len; j++) begin
                if (k < count) begin
                    exp_q.push_back(pat(seed, k));
                    kind_q.push_back(1);
                end else begin
                    exp_q.push_back(8'h00);              // R7 pad
                    kind_q.push_back(3);
                end
                k++;
            end
            if (crc) begin
                for (int t = 0; t < 2; t++) begin       // R5
                    exp_q.push_back(8'h00);
                    kind_q.push_back(2);
                end
            end
            rem -= len;
            first = 0;
        end
    endtask

    task automatic run(int count, bit crc, int code, int stl, int s, bit poke);
        int  cyc = 0;
        bit  got = 0;
        seed = s;
        stall = stl;
        ptr = 0;
        fires = 0;
        plan(count, crc, code);
        @(negedge clk);
        byte_count = CNT_W'(count);
        crc_en = crc;
        size_code = 3'(code);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        byte_count = '0;
        crc_en = ~crc;
        size_code = 3'(code + 1);
        while (!got && cyc < 150000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 40) begin
                start = 1'b1;            // R10: must be ignored
                byte_count = CNT_W'(3);
            end else begin
                start = 1'b0;
            end
            if (done) got = 1;
        end
        check(got, "R9 done timeout", cyc, 0);
        if (got) begin
            check(exp_q.size() == 0 && bit_idx == 0, "R9 done after final bit",
                  exp_q.size(), 0);
            check((count == 0) ? !prev_en : prev_en, "R9 done timing", prev_en, count != 0);
            check(fires == count, (count == 1) ? "R7 bytes taken" : "R8 bytes taken",
                  fires, count);
            if (poke) check(exp_q.size() == 0, "R10 stream unchanged", exp_q.size(), 0);
            @(negedge clk);
            check(!done && !busy, "R9 single pulse", done, 0);
        end
        exp_q.delete();
        kind_q.delete();
        bit_idx = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !mosi_en && !in_ready, "R11 reset state",
              {busy, done, mosi_en, in_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mosi_en, "R11 after reset release",
              {busy, done, mosi_en}, 0);
        run(1,   1'b0, 0, 0,  1, 0);   // R7 pad, no CRC
        run(1,   1'b1, 0, 30, 2, 0);   // R7 pad with trailer
        run(2,   1'b0, 0, 0,  3, 0);
        run(5,   1'b1, 2, 40, 4, 0);
        run(0,   1'b1, 0, 0,  5, 0);   // R9 empty transfer
        run(256, 1'b0, 0, 10, 6, 0);   // exact fit, R3 closing
        run(257, 1'b1, 0, 20, 7, 0);   // open then closing
        run(600, 1'b1, 0, 25, 8, 0);   // open, middle, closing
        run(513, 1'b0, 1, 0,  9, 0);   // R6 code 1
        run(300, 1'b0, 7, 15, 10, 0);  // R6 clamp code 7
        run(600, 1'b0, 0, 5,  11, 1);  // R10 start while busy
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule